// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where a 64-bit processor with 4-byte instructions fetches next. On each rising clock edge it takes the current program counter, a 3-bit control-transfer code from the decoder, a 16-bit signed branch displacement, a 26-bit jump index and two register operands. It registers the resulting next PC, a flag that says control flow left the straight-line path, and a return-address writeback (the incremented PC) aimed at register 31.

Conditional branches are relative to the incremented PC and count their displacement in whole instructions. Direct jumps stay inside the current 256 MiB region: they replace only the low 28 bits of the incremented PC. Register jumps load the full operand value. The two linking variants request the return-address write; the other codes never do. Fetch, hazard handling and prediction sit outside this block.

Top module: `npc_unit`

## Requirements
- R1: While reset is held, and until the first clock edge after it is released, `npc_o` is 0, `taken_o` is 0 and `link_we_o` is 0.
- R2: Every output updates on a rising edge from the inputs sampled at that edge. The codes on `ctl_i` are: 0 sequential, 1 branch-if-zero, 2 branch-not-equal, 3 direct jump, 4 direct jump with link, 5 register jump, 6 register jump with link, 7 handled as sequential. For the sequential codes `npc_o` = `pc_i` + 4 and `taken_o` = 0.
- R3: Code 1 is taken exactly when `rs_val_i` equals 0. `rt_val_i` has no effect on it.
- R4: Code 2 is taken exactly when `rs_val_i` differs from `rt_val_i`.
- R5: A taken branch gives `npc_o` = `pc_i` + 4 + sign-extended `br_off_i` × 4, which reaches −131072 to +131068 bytes. An untaken branch gives `npc_o` = `pc_i` + 4 and `taken_o` = 0.
- R6: Codes 3 and 4 give `npc_o` = {bits 63..28 of `pc_i`+4, `jmp_idx_i`, 2'b00}. The upper bits come from the incremented PC, even when the increment carries into bit 28.
- R7: Codes 5 and 6 give `npc_o` = `rs_val_i`, all 64 bits, unchanged.
- R8: `taken_o` is 1 for every jump code (3, 4, 5, 6).
- R9: `link_we_o` is 1 for codes 4 and 6 only. `link_addr_o` is always 31. `link_data_o` is always `pc_i` + 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 64 | Current program counter |
| ctl_i | input | 3 | Control-transfer code (encoding in R2) |
| br_off_i | input | 16 | Signed branch displacement in instructions |
| jmp_idx_i | input | 26 | Direct-jump instruction index |
| rs_val_i | input | 64 | First register operand (tested value or jump target) |
| rt_val_i | input | 64 | Second register operand for inequality test |
| npc_o | output | 64 | Registered next program counter |
| taken_o | output | 1 | Registered non-sequential flag |
| link_we_o | output | 1 | Registered return-address write enable |
| link_addr_o | output | 5 | Return-address destination register |
| link_data_o | output | 64 | Registered return address (PC + 4) |

## Verification
The scoreboard drives displacements at both extremes, 0x7FFF and 0x8000. A design that zero-extends or forgets the ×4 scaling lands far from the expected target. A direct jump is issued from a PC whose increment carries across the 28-bit region boundary, which catches a design that takes the upper bits from the unincremented PC. Branch-if-zero is run with a nonzero second operand, branch-not-equal with equal operands, and unused code 7 is driven; a design that decodes these loosely raises `taken_o` or moves the PC. Every code is checked against `link_we_o`, so a design that links on plain jumps fails.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      CT_SEQ   = 3'd0,
      CT_BRZ   = 3'd1,
      CT_BRNE  = 3'd2,
      CT_JDIR  = 3'd3,
      CT_JLNK  = 3'd4,
      CT_JREG  = 3'd5,
      CT_JLREG = 3'd6,
      CT_RSVD  = 3'd7
   } ctl_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
   parameter int XLEN       = 64,
   parameter int INSN_BYTES = 4
) (
   input  logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] seq_pc
);
   initial begin
      if (INSN_BYTES < 1 || (INSN_BYTES & (INSN_BYTES - 1)) != 0)
         $error("INSN_BYTES must be a power of two");
   end
   assign seq_pc = pc + XLEN'(INSN_BYTES);
endmodule

// File: rtl/npc_branch_tgt.sv
module npc_branch_tgt #(
   parameter int XLEN     = 64,
   parameter int OFS_W    = 16,
   parameter int ALIGN_SH = 2
) (
   input  logic [XLEN-1:0]  seq_pc,
   input  logic [OFS_W-1:0] ofs,
   output logic [XLEN-1:0]  tgt
);
   localparam int EXT_W = XLEN - OFS_W - ALIGN_SH;
   initial begin
      if (EXT_W < 1) $error("displacement too wide for XLEN");
   end
   logic [XLEN-1:0] disp;
   generate
      if (ALIGN_SH == 0) begin : g_byte
         assign disp = {{EXT_W{ofs[OFS_W-1]}}, ofs};
      end else begin : g_scaled
         assign disp = {{EXT_W{ofs[OFS_W-1]}}, ofs, {ALIGN_SH{1'b0}}};
      end
   endgenerate
   assign tgt = seq_pc + disp;
endmodule

// File: rtl/npc_region_tgt.sv
module npc_region_tgt #(
   parameter int XLEN     = 64,
   parameter int IDX_W    = 26,
   parameter int ALIGN_SH = 2
) (
   input  logic [XLEN-1:0]  seq_pc,
   input  logic [IDX_W-1:0] idx,
   output logic [XLEN-1:0]  tgt
);
   localparam int REGION_W = IDX_W + ALIGN_SH;
   initial begin
      if (REGION_W >= XLEN) $error("jump region must be narrower than XLEN");
   end
   generate
      if (ALIGN_SH == 0) begin : g_byte
         assign tgt = {seq_pc[XLEN-1:REGION_W], idx};
      end else begin : g_scaled
         assign tgt = {seq_pc[XLEN-1:REGION_W], idx, {ALIGN_SH{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/npc_cond.sv
module npc_cond #(
   parameter int XLEN = 64
) (
   input  npc_pkg::ctl_e  ctl,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic            br_take
);
   import npc_pkg::*;
   logic rs_zero, ops_differ;
   assign rs_zero    = (rs_val == '0);
   assign ops_differ = (rs_val != rt_val);
   always_comb begin
      case (ctl)
         CT_BRZ:  br_take = rs_zero;
         CT_BRNE: br_take = ops_differ;
         default: br_take = 1'b0;
      endcase
   end
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int          XLEN       = 64,
   parameter int          OFS_W      = 16,
   parameter int          IDX_W      = 26,
   parameter int          INSN_BYTES = 4,
   parameter int          RADDR_W    = 5,
   parameter int          LINK_REG   = 31,
   parameter logic [63:0] RESET_PC   = 64'd0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [XLEN-1:0]    pc_i,
   input  logic [2:0]         ctl_i,
   input  logic [OFS_W-1:0]   br_off_i,
   input  logic [IDX_W-1:0]   jmp_idx_i,
   input  logic [XLEN-1:0]    rs_val_i,
   input  logic [XLEN-1:0]    rt_val_i,
   output logic [XLEN-1:0]    npc_o,
   output logic               taken_o,
   output logic               link_we_o,
   output logic [RADDR_W-1:0] link_addr_o,
   output logic [XLEN-1:0]    link_data_o
);
   import npc_pkg::*;

   localparam int ALIGN_SH = $clog2(INSN_BYTES);
   localparam int REGION_W = IDX_W + ALIGN_SH;

   initial begin
      if (LINK_REG >= (1 << RADDR_W)) $error("LINK_REG does not fit RADDR_W");
      if (XLEN > 64) $error("RESET_PC limits XLEN to 64");
   end

   ctl_e            ctl;
   logic [XLEN-1:0] seq_pc, br_tgt, rg_tgt, npc_d;
   logic            br_take, taken_d, link_d;

   assign ctl = ctl_e'(ctl_i);

   npc_incr #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_incr (
      .pc(pc_i), .seq_pc(seq_pc));

   npc_branch_tgt #(.XLEN(XLEN), .OFS_W(OFS_W), .ALIGN_SH(ALIGN_SH)) u_btgt (
      .seq_pc(seq_pc), .ofs(br_off_i), .tgt(br_tgt));

   npc_region_tgt #(.XLEN(XLEN), .IDX_W(IDX_W), .ALIGN_SH(ALIGN_SH)) u_rtgt (
      .seq_pc(seq_pc), .idx(jmp_idx_i), .tgt(rg_tgt));

   npc_cond #(.XLEN(XLEN)) u_cond (
      .ctl(ctl), .rs_val(rs_val_i), .rt_val(rt_val_i), .br_take(br_take));

   always_comb begin
      npc_d   = seq_pc;
      taken_d = 1'b0;
      link_d  = 1'b0;
      case (ctl)
         CT_BRZ, CT_BRNE: begin
            if (br_take) begin
               npc_d   = br_tgt;
               taken_d = 1'b1;
            end
         end
         CT_JDIR, CT_JLNK: begin
            npc_d   = rg_tgt;
            taken_d = 1'b1;
            link_d  = (ctl == CT_JLNK);
         end
         CT_JREG, CT_JLREG: begin
            npc_d   = rs_val_i;
            taken_d = 1'b1;
            link_d  = (ctl == CT_JLREG);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         npc_o       <= RESET_PC[XLEN-1:0];
         taken_o     <= 1'b0;
         link_we_o   <= 1'b0;
         link_data_o <= '0;
      end else begin
         npc_o       <= npc_d;
         taken_o     <= taken_d;
         link_we_o   <= link_d;
         link_data_o <= seq_pc;
      end
   end

   assign link_addr_o = RADDR_W'(LINK_REG);

   // Checks: active only once a full post-reset cycle has registered.
   logic primed_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed_q <= 1'b0;
      else        primed_q <= 1'b1;
   end

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!taken_o && !link_we_o) || rst_n); // R1

   AST_SEQ_NEXT: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      ($past(ctl_i) == 3'd0 || $past(ctl_i) == 3'd7)
      |-> (npc_o == $past(pc_i) + XLEN'(INSN_BYTES)) && !taken_o); // R2

   AST_UNTAKEN_SEQ: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      !taken_o |-> npc_o == $past(pc_i) + XLEN'(INSN_BYTES)); // R5

   AST_REGION_KEEP: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      ($past(ctl_i) == 3'd3 || $past(ctl_i) == 3'd4)
      |-> npc_o[XLEN-1:REGION_W] == link_data_o[XLEN-1:REGION_W]); // R6

   AST_REG_TARGET: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      ($past(ctl_i) == 3'd5 || $past(ctl_i) == 3'd6) |-> npc_o == $past(rs_val_i)); // R7

   AST_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      ($past(ctl_i) >= 3'd3 && $past(ctl_i) <= 3'd6) |-> taken_o); // R8

   AST_LINK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      link_we_o |-> ($past(ctl_i) == 3'd4 || $past(ctl_i) == 3'd6) && taken_o); // R9

   AST_LINK_DATA: assert property (@(posedge clk) disable iff (!rst_n || !primed_q)
      link_data_o == $past(pc_i) + XLEN'(INSN_BYTES)); // R9
endmodule

// File: tb/tb_npc_unit.sv
`timescale 1ns/1ps
module tb_npc_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] pc_i = '0;
   logic [2:0]  ctl_i = '0;
   logic [15:0] br_off_i = '0;
   logic [25:0] jmp_idx_i = '0;
   logic [63:0] rs_val_i = '0;
   logic [63:0] rt_val_i = '0;
   logic [63:0] npc_o;
   logic        taken_o;
   logic        link_we_o;
   logic [4:0]  link_addr_o;
   logic [63:0] link_data_o;

   always #2 clk = ~clk;

   npc_unit dut (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .ctl_i(ctl_i),
      .br_off_i(br_off_i), .jmp_idx_i(jmp_idx_i),
      .rs_val_i(rs_val_i), .rt_val_i(rt_val_i),
      .npc_o(npc_o), .taken_o(taken_o), .link_we_o(link_we_o),
      .link_addr_o(link_addr_o), .link_data_o(link_data_o));

   typedef struct packed {
      logic [63:0] npc;
      logic        taken;
      logic        lwe;
      logic [63:0] ldata;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   function automatic exp_t model(input logic [63:0] pc, input logic [2:0] ctl,
                                  input logic [15:0] off, input logic [25:0] idx,
                                  input logic [63:0] rs, input logic [63:0] rt);
      exp_t e;
      logic [63:0] s;
      s = pc + 64'd4;
      e.npc = s; e.taken = 1'b0; e.lwe = 1'b0; e.ldata = s;
      case (ctl)
         3'd1: if (rs == 64'd0) begin
            e.taken = 1'b1; e.npc = s + {{46{off[15]}}, off, 2'b00};
         end
         3'd2: if (rs != rt) begin
            e.taken = 1'b1; e.npc = s + {{46{off[15]}}, off, 2'b00};
         end
         3'd3, 3'd4: begin
            e.taken = 1'b1; e.npc = {s[63:28], idx, 2'b00}; e.lwe = (ctl == 3'd4);
         end
         3'd5, 3'd6: begin
            e.taken = 1'b1; e.npc = rs; e.lwe = (ctl == 3'd6);
         end
         default: ;
      endcase
      return e;
   endfunction

   task automatic drive(input logic [63:0] pc, input logic [2:0] ctl,
                        input logic [15:0] off, input logic [25:0] idx,
                        input logic [63:0] rs, input logic [63:0] rt, input string tag);
      @(negedge clk);
      pc_i = pc; ctl_i = ctl; br_off_i = off; jmp_idx_i = idx;
      rs_val_i = rs; rt_val_i = rt;
      exp_q.push_back(model(pc, ctl, off, idx, rs, rt));
      tag_q.push_back(tag);
   endtask

   // Monitor: compares registered outputs just after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (npc_o !== e.npc || taken_o !== e.taken || link_we_o !== e.lwe ||
                link_data_o !== e.ldata || link_addr_o !== 5'd31) begin
               n_bad++;
               $display("FAIL %s: npc=%h taken=%b lwe=%b ldata=%h laddr=%0d exp npc=%h taken=%b lwe=%b ldata=%h laddr=31",
                        t, npc_o, taken_o, link_we_o, link_data_o, link_addr_o,
                        e.npc, e.taken, e.lwe, e.ldata);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, exp done=1 got 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++; // R1 reset state
      if (npc_o !== 64'd0 || taken_o !== 1'b0 || link_we_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: npc=%h taken=%b lwe=%b exp npc=0 taken=0 lwe=0",
                  npc_o, taken_o, link_we_o);
      end
      rst_n = 1'b1;

      drive(64'h0000_0000_0000_1000, 3'd0, 16'h0010, 26'h0, 64'd5, 64'd6, "R2 sequential");
      drive(64'h0000_0000_0000_2000, 3'd7, 16'h0010, 26'h3, 64'd0, 64'd0, "R2 code7 as sequential");
      drive(64'h0000_0000_0000_3000, 3'd1, 16'h0008, 26'h0, 64'd0, 64'hDEAD, "R3 brz taken rt ignored");
      drive(64'h0000_0000_0000_3000, 3'd1, 16'h0008, 26'h0, 64'h100, 64'd0, "R3 brz not taken");
      drive(64'h0000_0000_0000_4000, 3'd2, 16'h0004, 26'h0, 64'd7, 64'd7, "R4 bne equal not taken");
      drive(64'h0000_0000_0000_4000, 3'd2, 16'h0004, 26'h0, 64'd7, 64'd8, "R4 bne differ taken");
      drive(64'h0000_0000_0010_0000, 3'd1, 16'h7FFF, 26'h0, 64'd0, 64'd0, "R5 max forward offset");
      drive(64'h0000_0000_0010_0000, 3'd1, 16'h8000, 26'h0, 64'd0, 64'd0, "R5 max backward offset");
      drive(64'h0000_0000_0000_5000, 3'd2, 16'hFFFF, 26'h0, 64'd1, 64'd2, "R5 offset minus one");
      drive(64'hABCD_0000_0FFF_FFFC, 3'd3, 16'h0, 26'h155_5555, 64'd0, 64'd0, "R6 region carry");
      drive(64'h1234_5678_9ABC_DEF0, 3'd3, 16'h0, 26'h000_0001, 64'd0, 64'd0, "R6 direct jump R8");
      drive(64'h1234_5678_9ABC_DEF0, 3'd4, 16'h0, 26'h3FF_FFFF, 64'd0, 64'd0, "R9 jump link");
      drive(64'h0000_0000_0000_6000, 3'd5, 16'h0, 26'h0, 64'hFEDC_BA98_7654_3211, 64'd0, "R7 register jump");
      drive(64'h0000_0000_0000_7000, 3'd6, 16'h0, 26'h0, 64'h8000_0000_0000_0000, 64'd1, "R9 register jump link R7");
      drive(64'hFFFF_FFFF_FFFF_FFFC, 3'd0, 16'h0, 26'h0, 64'd0, 64'd0, "R2 wrap at top");

      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule